// File: doc/BRIEF.md
# Effective Address Generation Unit

This block forms the memory offset that a load or store uses. It adds up to three terms: a displacement, a base register value and an index register value multiplied by a power of two. In 64-bit mode it can instead form the address from the next-instruction pointer plus a 32-bit offset, and that path uses no general register. The register file and decode stages supply the operands and flags. The result comes out of a register one cycle after the request, together with a valid flag and an illegal-encoding flag.

A mode input picks 32-bit or 64-bit addressing. In 32-bit mode the sum is cut to 32 bits and zero-extended, so any carry past bit 31 is lost. Every displacement is sign-extended to the full address width before the addition. When the index register number names the stack pointer, no index term is added. Requests that cannot be encoded are reported as illegal with a zero address. The valid flag is still raised for them, so the pipeline sees an outcome on every request.

Top module: `eff_addr_gen`

## Requirements
- R1: `eaValid` goes high exactly one clock edge after an edge where `inValid` is high, and is low after any edge where `inValid` is low. A synchronous active-high reset clears `eaValid`, `eaIllegal` and `ea`.
- R2: In 64-bit mode (`is64`=1, `ripRel`=0), `ea` = base + index*scale + displacement, taken modulo 2^64.
- R3: `scale` codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R4: `dispSize` code 0 adds no displacement. Code 1 uses `disp[7:0]`, code 2 uses `disp[31:0]` and code 3 uses `disp[15:0]`. Each is sign-extended to 64 bits, so -128, +127 and 0x80000000 contribute as signed values.
- R5: When `indexValid`=1 and `indexNum` equals 4 (the stack pointer), no index term is added.
- R6: When `baseValid`=0, no base term is added and the form is legal.
- R7: In 32-bit mode (`is64`=0), `ea[31:0]` is the sum modulo 2^32 and `ea[63:32]` is zero.
- R8: With `ripRel`=1 and `is64`=1, `ea` = `nextIp` + sign-extended `disp[31:0]`. The base, index, scale and `dispSize` inputs are ignored.
- R9: With `ripRel`=1 and `is64`=0, `eaIllegal` is set, `ea` is zero and `eaValid` is still set.
- R10: When `dispSize`=3 appears with a nonzero `scale`, or with an index term present, `eaIllegal` is set and `ea` is zero. With no index and scale 0, the 16-bit form is legal.
- R11: On a clock edge where `inValid` is low, `ea` keeps its value and `eaIllegal` reads low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request present this cycle |
| is64 | input | 1 | 1 = 64-bit addressing, 0 = 32-bit |
| ripRel | input | 1 | Instruction-pointer-relative form |
| baseValid | input | 1 | Base term present |
| baseVal | input | 64 | Base register value |
| indexValid | input | 1 | Index field present |
| indexNum | input | 4 | Index register number (4 = none) |
| indexVal | input | 64 | Index register value |
| scale | input | 2 | Index shift count |
| dispSize | input | 2 | Displacement size code |
| disp | input | 32 | Raw displacement bits |
| nextIp | input | 64 | Next-instruction pointer |
| eaValid | output | 1 | Registered result valid |
| ea | output | 64 | Registered effective address |
| eaIllegal | output | 1 | Registered illegal-encoding flag |

## Verification
The hardest outcomes to see from the ports are the ones where an input must have no effect. Two examples are an index value under register number 4, and base and index values during an instruction-pointer-relative request. The bench loads large nonzero values into the ignored operands, so any leak changes the address it checks. Carries past bit 31 in 32-bit mode are forced with operands near 0xFFFFFFFF. The 16-bit illegal case is applied once with a scale and once with only an index.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_8    = 2'd1,
    DISP_32   = 2'd2,
    DISP_16   = 2'd3
  } dispSize_e;

  typedef struct packed {
    logic load;
    logic useBase;
    logic useIndex;
    logic useRip;
    logic trunc32;
    logic illegal;
  } eagStrobes_t;
endpackage

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
#(
  parameter int REG_NUM_W = 4,
  parameter int SP_NUM    = 4
) (
  input  logic                 inValid,
  input  logic                 is64,
  input  logic                 ripRel,
  input  logic                 baseValid,
  input  logic                 indexValid,
  input  logic [REG_NUM_W-1:0] indexNum,
  input  logic [1:0]           scale,
  input  logic [1:0]           dispSize,
  output eagStrobes_t          strobes
);
  localparam logic [REG_NUM_W-1:0] SP_CODE = REG_NUM_W'(SP_NUM);

  logic indexPresent;
  logic badRip;
  logic badDisp16;

  always_comb begin
    indexPresent = indexValid && (indexNum != SP_CODE);
    badRip       = ripRel && !is64;
    badDisp16    = !ripRel && (dispSize == DISP_16) &&
                   ((scale != 2'd0) || indexPresent);

    strobes.load     = inValid;
    strobes.useRip   = ripRel && is64;
    strobes.useBase  = !ripRel && baseValid;
    strobes.useIndex = !ripRel && indexPresent;
    strobes.trunc32  = !is64;
    strobes.illegal  = badRip || badDisp16;
  end
endmodule

// File: rtl/eag_datapath.sv
module eag_datapath
  import eag_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int DISP_W  = 32,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  eagStrobes_t       strobes,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] indexVal,
  input  logic [1:0]        scale,
  input  logic [1:0]        dispSize,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] nextIp,
  output logic              eaValid,
  output logic [ADDR_W-1:0] ea,
  output logic              eaIllegal
);
  localparam int HI_W = ADDR_W - NARROW_W;

  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] baseTerm;
  logic [ADDR_W-1:0] indexTerm;
  logic [ADDR_W-1:0] rawSum;
  logic [ADDR_W-1:0] nextEa;

  always_comb begin
    if (strobes.useRip) begin
      dispExt = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
    end else begin
      unique case (dispSize_e'(dispSize))
        DISP_8:  dispExt = {{(ADDR_W-8){disp[7]}}, disp[7:0]};
        DISP_16: dispExt = {{(ADDR_W-16){disp[15]}}, disp[15:0]};
        DISP_32: dispExt = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
        default: dispExt = '0;
      endcase
    end

    baseTerm  = strobes.useRip  ? nextIp :
                strobes.useBase ? baseVal : '0;
    indexTerm = strobes.useIndex ? (indexVal << scale) : '0;
    rawSum    = baseTerm + indexTerm + dispExt;

    if (strobes.illegal) begin
      nextEa = '0;
    end else if (strobes.trunc32) begin
      nextEa = {{HI_W{1'b0}}, rawSum[NARROW_W-1:0]};
    end else begin
      nextEa = rawSum;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eaValid   <= 1'b0;
      eaIllegal <= 1'b0;
      ea        <= '0;
    end else begin
      eaValid   <= strobes.load;
      eaIllegal <= strobes.load && strobes.illegal;
      if (strobes.load) begin
        ea <= nextEa;
      end
    end
  end
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import eag_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int DISP_W    = 32,
  parameter int REG_NUM_W = 4,
  parameter int SP_NUM    = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic                 is64,
  input  logic                 ripRel,
  input  logic                 baseValid,
  input  logic [ADDR_W-1:0]    baseVal,
  input  logic                 indexValid,
  input  logic [REG_NUM_W-1:0] indexNum,
  input  logic [ADDR_W-1:0]    indexVal,
  input  logic [1:0]           scale,
  input  logic [1:0]           dispSize,
  input  logic [DISP_W-1:0]    disp,
  input  logic [ADDR_W-1:0]    nextIp,
  output logic                 eaValid,
  output logic [ADDR_W-1:0]    ea,
  output logic                 eaIllegal
);
  eagStrobes_t strobes;

  eag_ctrl #(
    .REG_NUM_W (REG_NUM_W),
    .SP_NUM    (SP_NUM)
  ) u_ctrl (
    .inValid    (inValid),
    .is64       (is64),
    .ripRel     (ripRel),
    .baseValid  (baseValid),
    .indexValid (indexValid),
    .indexNum   (indexNum),
    .scale      (scale),
    .dispSize   (dispSize),
    .strobes    (strobes)
  );

  eag_datapath #(
    .ADDR_W   (ADDR_W),
    .DISP_W   (DISP_W),
    .NARROW_W (32)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .baseVal   (baseVal),
    .indexVal  (indexVal),
    .scale     (scale),
    .dispSize  (dispSize),
    .disp      (disp),
    .nextIp    (nextIp),
    .eaValid   (eaValid),
    .ea        (ea),
    .eaIllegal (eaIllegal)
  );
endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              is64,
  input logic              ripRel,
  input logic              eaValid,
  input logic [ADDR_W-1:0] ea,
  input logic              eaIllegal
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    inValid |=> eaValid); // R1
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !eaValid); // R1
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (inValid && !is64) |=> (ea[ADDR_W-1:32] == '0)); // R7
  AST_RIP_NARROW_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    (inValid && !is64 && ripRel) |=> (eaIllegal && eaValid && ea == '0)); // R9
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    eaIllegal |-> (ea == '0)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(ea) && !eaIllegal)); // R11
endmodule

bind eff_addr_gen eag_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .inValid   (inValid),
  .is64      (is64),
  .ripRel    (ripRel),
  .eaValid   (eaValid),
  .ea        (ea),
  .eaIllegal (eaIllegal)
);

// File: tb/sim_eff_addr_gen.sv
module sim_eff_addr_gen;
  logic        clk = 1'b0;
  logic        rst;
  logic        inValid, is64, ripRel, baseValid, indexValid;
  logic [63:0] baseVal, indexVal, nextIp;
  logic [3:0]  indexNum;
  logic [1:0]  scale, dispSize;
  logic [31:0] disp;
  logic        eaValid, eaIllegal;
  logic [63:0] ea;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  eff_addr_gen u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .is64(is64), .ripRel(ripRel),
    .baseValid(baseValid), .baseVal(baseVal), .indexValid(indexValid),
    .indexNum(indexNum), .indexVal(indexVal), .scale(scale),
    .dispSize(dispSize), .disp(disp), .nextIp(nextIp),
    .eaValid(eaValid), .ea(ea), .eaIllegal(eaIllegal)
  );

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] dispValue(input logic [1:0] sz,
                                            input logic [31:0] d);
    case (sz)
      2'd1:    return 64'($signed(d[7:0]));
      2'd2:    return 64'($signed(d));
      2'd3:    return 64'($signed(d[15:0]));
      default: return 64'd0;
    endcase
  endfunction

  task automatic setIn(input logic m64, input logic rip, input logic bv,
                       input logic [63:0] b, input logic iv,
                       input logic [3:0] inum, input logic [63:0] ix,
                       input logic [1:0] sc, input logic [1:0] ds,
                       input logic [31:0] d);
    inValid = 1'b1; is64 = m64; ripRel = rip; baseValid = bv; baseVal = b;
    indexValid = iv; indexNum = inum; indexVal = ix; scale = sc;
    dispSize = ds; disp = d;
  endtask

  // One request, sampled on the falling edge after the registering edge.
  task automatic fire(input string req, input logic [63:0] expEa,
                      input logic expIll);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    check(req, {63'd0, eaValid}, 64'd1);
    check(req, ea, expEa);
    check(req, {63'd0, eaIllegal}, {63'd0, expIll});
  endtask

  task automatic testReset();
    check("R1", {63'd0, eaValid}, 64'd0);
    check("R1", ea, 64'd0);
    check("R1", {63'd0, eaIllegal}, 64'd0);
  endtask

  task automatic testDisp8Bounds();
    setIn(1, 0, 1, 64'h1000, 0, 0, 0, 0, 2'd1, 32'h0000_0080);
    fire("R4", 64'h1000 - 64'd128, 0);
    setIn(1, 0, 1, 64'h1000, 0, 0, 0, 0, 2'd1, 32'hFFFF_FF7F);
    fire("R4", 64'h1000 + 64'd127, 0);
    setIn(1, 0, 1, 64'h1000, 0, 0, 0, 0, 2'd0, 32'h1234_5678);
    fire("R4", 64'h1000, 0);
  endtask

  task automatic testDisp32Bounds();
    setIn(1, 0, 1, 64'h1_0000_0000, 0, 0, 0, 0, 2'd2, 32'h8000_0000);
    fire("R4", 64'h0000_0000_8000_0000, 0);
    setIn(0, 0, 1, 64'h9000_0000, 0, 0, 0, 0, 2'd2, 32'h8000_0000);
    fire("R7", 64'h0000_0000_1000_0000, 0);
  endtask

  task automatic testScales();
    for (int s = 0; s < 4; s++) begin
      setIn(1, 0, 1, 64'h100, 1, 4'd3, 64'h10, 2'(s), 2'd0, 0);
      fire("R3", 64'h100 + (64'h10 << s), 0);
    end
  endtask

  task automatic testNoIndexNoBase();
    setIn(1, 0, 1, 64'h500, 1, 4'd4, 64'hDEAD_BEEF_0000, 2'd3, 2'd1, 32'h4);
    fire("R5", 64'h504, 0);
    setIn(1, 0, 0, 64'hFFFF_0000, 1, 4'd2, 64'h20, 2'd2, 2'd2, 32'h1000);
    fire("R6", 64'h1080, 0);
  endtask

  task automatic testNarrowCarry();
    setIn(0, 0, 1, 64'hFFFF_FFF0, 1, 4'd1, 64'h20, 2'd0, 2'd1, 32'h1);
    fire("R7", 64'h0000_0000_0000_0011, 0);
  endtask

  task automatic testRip();
    nextIp = 64'h0000_7FFF_0000_1000;
    setIn(1, 1, 1, 64'hAAAA, 1, 4'd1, 64'h5555, 2'd3, 2'd1, 32'hFFFF_FF00);
    fire("R8", 64'h0000_7FFF_0000_0F00, 0);
    setIn(0, 1, 1, 64'hAAAA, 0, 0, 0, 0, 2'd2, 32'h10);
    fire("R9", 64'd0, 1);
  endtask

  task automatic testDisp16();
    setIn(1, 0, 1, 64'h100, 0, 0, 0, 2'd1, 2'd3, 32'h8);
    fire("R10", 64'd0, 1);
    setIn(1, 0, 1, 64'h100, 1, 4'd2, 64'h4, 2'd0, 2'd3, 32'h8);
    fire("R10", 64'd0, 1);
    setIn(1, 0, 1, 64'h100, 0, 0, 0, 2'd0, 2'd3, 32'h0000_FFFE);
    fire("R10", 64'hFE, 0);
  endtask

  task automatic testHold();
    setIn(1, 0, 1, 64'h4242, 0, 0, 0, 0, 2'd0, 0);
    fire("R11", 64'h4242, 0);
    baseVal = 64'h9999;
    @(posedge clk);
    @(negedge clk);
    check("R1", {63'd0, eaValid}, 64'd0);
    check("R11", ea, 64'h4242);
    check("R11", {63'd0, eaIllegal}, 64'd0);
  endtask

  task automatic testRandom();
    for (int n = 0; n < 40; n++) begin
      logic [63:0] b, x, expv;
      logic [1:0]  sc, ds;
      logic [31:0] d;
      logic [3:0]  inum;
      b    = {$urandom, $urandom};
      x    = {$urandom, $urandom};
      sc   = 2'($urandom);
      ds   = 2'($urandom_range(0, 2));
      d    = $urandom;
      inum = 4'($urandom);
      setIn(1, 0, 1, b, 1, inum, x, sc, ds, d);
      expv = b + dispValue(ds, d) + ((inum == 4'd4) ? 64'd0 : x * (64'd1 << sc));
      fire("R2", expv, 0);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    inValid = 0; is64 = 1; ripRel = 0; baseValid = 0; indexValid = 0;
    baseVal = 0; indexVal = 0; indexNum = 0; scale = 0; dispSize = 0;
    disp = 0; nextIp = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rst = 1'b0;
    testDisp8Bounds();
    testDisp32Bounds();
    testScales();
    testNoIndexNoBase();
    testNarrowCarry();
    testRip();
    testDisp16();
    testHold();
    testRandom();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule